// File: doc/BRIEF.md
# Serial Command and Status Slave Port

This block is the serial slave end of a command link. An external master lowers a select line and clocks bytes in on a data line. Each complete byte goes to the logic behind the port as a parallel command with a strobe. While the same bytes are being clocked in, a parallel status word from the channel logic is shifted back out, one bit per clock, on a data line that the port drives only while it is selected. A static mode input chooses which serial-clock edge samples incoming data and which edge moves outgoing status. Raising select puts the port back into its idle state, wherever it was in a byte.

All serial inputs pass through a synchroniser into the system clock domain, and edges are found there. The system clock must therefore run at least four times faster than the serial clock. Commands leave on a one-cycle strobe (`cmd_valid`) with no ready signal and no back-pressure. The receiving logic must take the byte in the cycle the strobe is high. The next strobe cannot come sooner than eight serial-clock edges later. `cmd_data` keeps its last value between strobes. The output data bit and its enable come out separately, and the chip-level pad combines them into a three-state pin.

Top module: `ser_cmd_port`

## Requirements
- R1: Command bytes are `DATA_W` bits, most significant bit first. A complete byte appears on `cmd_data` together with a `cmd_valid` pulse exactly one system clock wide.
- R2: With `sample_on_fall` low, `spi_mosi` is sampled on rising `spi_sck` edges and status bits advance on falling edges.
- R3: With `sample_on_fall` high, `spi_mosi` is sampled on falling `spi_sck` edges and status bits advance on rising edges.
- R4: The strobe follows the eighth sampling edge with no further serial clocking. `cmd_valid` goes high on the third rising system-clock edge after that serial edge reaches the pin.
- R5: Raising `spi_cs_n` clears any partial bit count. A byte cut short by deselect produces no strobe, and the next selected byte is received aligned.
- R6: `miso_oe` is low while the synchronised select is high and high while it is low.
- R7: When select goes low, the port captures `stat_word` and presents its most significant bit on `miso` before the first shifting edge. `miso` changes only on a load or a shifting edge.
- R8: On the eighth shifting edge of a byte, `stat_word` is captured again, so each byte in a burst returns the current status.
- R9: With select held low, the bit count wraps every `DATA_W` sampling edges. One spurious clock pulse shifts the alignment of all later bytes until select is raised.
- R10: `cmd_valid` is never asserted while the port is deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Active-low select from the master |
| spi_sck | input | 1 | Serial clock from the master |
| spi_mosi | input | 1 | Serial command data in |
| sample_on_fall | input | 1 | Static edge mode: 0 samples on rising edges, 1 on falling edges |
| stat_word | input | DATA_W | Parallel per-channel status to return |
| cmd_valid | output | 1 | One-cycle strobe for a complete command |
| cmd_data | output | DATA_W | Assembled command byte |
| miso | output | 1 | Serial status data out |
| miso_oe | output | 1 | Output enable for the three-state status pin |

## Verification
The bench uses the default parameters: `DATA_W` = 8 and `SYNC_STAGES` = 2. With these values the reference model can track the synchroniser delay cycle for cycle, so the three-clock strobe latency and the one-cycle status load are checked exactly. The serial half-period is six system clocks, and the injected glitch pulse is four clocks wide. This places the glitch near the speed limit at which edges can still be detected, and it exercises edge detection in both modes, with bursts and aborted bytes.

// File: rtl/scp_pkg.sv
package scp_pkg;
  // Per-cycle events derived from the synchronised serial pins.
  typedef struct packed {
    logic active;    // select asserted (synchronised)
    logic sel_fall;  // select just asserted
    logic sample;    // sampling edge seen while active
    logic shift;     // shifting edge seen while active
  } scp_evt_t;
endpackage

// File: rtl/scp_sync.sv
module scp_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/scp_edge.sv
module scp_edge
  import scp_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cs_n_s,
  input  logic     sck_s,
  input  logic     sample_on_fall,
  output scp_evt_t evt
);
  logic cs_n_d, sck_d;
  logic sck_rise, sck_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n_d <= 1'b1;
      sck_d  <= 1'b0;
    end else begin
      cs_n_d <= cs_n_s;
      sck_d  <= sck_s;
    end
  end

  assign sck_rise = sck_s & ~sck_d;
  assign sck_fall = ~sck_s & sck_d;

  always_comb begin
    evt.active   = ~cs_n_s;
    evt.sel_fall = cs_n_d & ~cs_n_s;
    evt.sample   = ~cs_n_s & (sample_on_fall ? sck_fall : sck_rise);
    evt.shift    = ~cs_n_s & (sample_on_fall ? sck_rise : sck_fall);
  end
endmodule

// File: rtl/scp_rx.sv
module scp_rx
  import scp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  scp_evt_t          evt,
  input  logic              mosi_s,
  output logic              cmd_valid,
  output logic [DATA_W-1:0] cmd_data
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] sr;
  logic [DATA_W-1:0] nxt;

  assign nxt = {sr[DATA_W-2:0], mosi_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      sr        <= '0;
      cmd_valid <= 1'b0;
      cmd_data  <= '0;
    end else begin
      cmd_valid <= 1'b0;
      if (!evt.active) begin
        cnt <= '0;
      end else if (evt.sample) begin
        sr <= nxt;
        if (cnt == LAST) begin
          cnt       <= '0;
          cmd_valid <= 1'b1;
          cmd_data  <= nxt;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/scp_tx.sv
module scp_tx
  import scp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  scp_evt_t          evt,
  input  logic [DATA_W-1:0] stat_word,
  output logic              miso,
  output logic              load_evt
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] sr;
  logic              wrap;

  assign wrap     = evt.shift & (cnt == LAST);
  assign load_evt = evt.sel_fall | wrap;
  assign miso     = sr[DATA_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      sr  <= '0;
    end else if (evt.sel_fall) begin
      cnt <= '0;
      sr  <= stat_word;
    end else if (!evt.active) begin
      cnt <= '0;
    end else if (evt.shift) begin
      if (wrap) begin
        cnt <= '0;
        sr  <= stat_word;
      end else begin
        cnt <= cnt + 1'b1;
        sr  <= {sr[DATA_W-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/ser_cmd_port.sv
module ser_cmd_port
  import scp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_cs_n,
  input  logic              spi_sck,
  input  logic              spi_mosi,
  input  logic              sample_on_fall,
  input  logic [DATA_W-1:0] stat_word,
  output logic              cmd_valid,
  output logic [DATA_W-1:0] cmd_data,
  output logic              miso,
  output logic              miso_oe
);
  localparam int PIN_W = 3;
  localparam logic [PIN_W-1:0] PIN_RST = 3'b100;

  logic [PIN_W-1:0] pins_s;
  scp_evt_t         evt;
  logic             sample_evt, shift_evt, load_evt;

  scp_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({spi_cs_n, spi_sck, spi_mosi}),
    .q(pins_s)
  );

  scp_edge u_edge (
    .clk(clk), .rst_n(rst_n),
    .cs_n_s(pins_s[2]), .sck_s(pins_s[1]),
    .sample_on_fall(sample_on_fall),
    .evt(evt)
  );

  scp_rx #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .evt(evt), .mosi_s(pins_s[0]),
    .cmd_valid(cmd_valid), .cmd_data(cmd_data)
  );

  scp_tx #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .evt(evt), .stat_word(stat_word),
    .miso(miso), .load_evt(load_evt)
  );

  assign miso_oe    = evt.active;
  assign sample_evt = evt.sample;
  assign shift_evt  = evt.shift;
endmodule

// File: rtl/ser_cmd_port_chk.sv
module ser_cmd_port_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_valid,
  input logic miso,
  input logic miso_oe,
  input logic sample_evt,
  input logic shift_evt,
  input logic load_evt
);
  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid); // R1
  AST_EDGES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_evt && shift_evt)); // R2
  AST_STROBE_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_valid) |-> $past(sample_evt)); // R4
  AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !miso_oe |=> !cmd_valid); // R10
  AST_MISO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_evt && !shift_evt) |=> $stable(miso)); // R7
endmodule

bind ser_cmd_port ser_cmd_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .miso(miso),
  .miso_oe(miso_oe), .sample_evt(sample_evt), .shift_evt(shift_evt),
  .load_evt(load_evt)
);

// File: tb/tb_ser_cmd_port.sv
module tb_ser_cmd_port;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_cs_n = 1'b1, spi_sck = 1'b0, spi_mosi = 1'b0, sample_on_fall = 1'b0;
  logic [7:0] stat_word = 8'h00;
  logic cmd_valid, miso, miso_oe;
  logic [7:0] cmd_data;

  int vectors = 0, fails = 0;
  bit done = 0;
  logic [7:0] obs [$];

  always #4 clk = ~clk;

  ser_cmd_port dut (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .sample_on_fall(sample_on_fall), .stat_word(stat_word),
    .cmd_valid(cmd_valid), .cmd_data(cmd_data), .miso(miso), .miso_oe(miso_oe)
  );

  task automatic check(string tag, int got, int exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  // Behavioural reference: pins seen two clocks late, edges against a third.
  int c1, c2, c3, k1, k2, k3, d1, d2;
  int rcnt, rsr, tcnt, tsr;
  int e_valid, e_data, e_oe;
  always @(posedge clk) begin
    if (!rst_n) begin
      c1 = 1; c2 = 1; c3 = 1; k1 = 0; k2 = 0; k3 = 0; d1 = 0; d2 = 0;
      rcnt = 0; rsr = 0; tcnt = 0; tsr = 0; e_valid = 0; e_data = 0; e_oe = 0;
    end else begin
      int act, selfall, rise, fall, samp, shf;
      act = !c2; selfall = c3 && !c2;
      rise = k2 && !k3; fall = !k2 && k3;
      samp = act && (sample_on_fall ? fall : rise);
      shf  = act && (sample_on_fall ? rise : fall);
      e_valid = 0;
      if (!act) rcnt = 0;
      else if (samp) begin
        rsr = ((rsr << 1) | d2) & 255;
        if (rcnt == 7) begin e_valid = 1; e_data = rsr; rcnt = 0; end
        else rcnt++;
      end
      if (selfall) begin tcnt = 0; tsr = stat_word; end
      else if (!act) tcnt = 0;
      else if (shf) begin
        if (tcnt == 7) begin tcnt = 0; tsr = stat_word; end
        else begin tcnt++; tsr = (tsr << 1) & 255; end
      end
      c3 = c2; c2 = c1; c1 = spi_cs_n;
      k3 = k2; k2 = k1; k1 = spi_sck;
      d2 = d1; d1 = spi_mosi;
      e_oe = !c2;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R1/R4 cmd_valid", cmd_valid, e_valid);
      if (e_valid) check("R1 cmd_data", cmd_data, e_data);
      check("R6 miso_oe", miso_oe, e_oe);
      if (e_oe) check("R7/R8 miso", miso, (tsr >> 7) & 1);
      if (cmd_valid) obs.push_back(cmd_data);
    end
  end

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic select(bit on);
    spi_cs_n = !on;
    wait_clk(HALF);
  endtask

  // Send nbits of tx MSB first; return status bits seen before each sampling edge.
  task automatic xfer(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - nbits; i--) begin
      spi_mosi = tx[i];
      wait_clk(HALF);
      rx[i] = miso;
      spi_sck = !sample_on_fall;
      wait_clk(HALF);
      spi_sck = sample_on_fall;
    end
    wait_clk(4);
  endtask

  task automatic glitch(input logic b);
    spi_mosi = b;
    wait_clk(4); spi_sck = !sample_on_fall;
    wait_clk(4); spi_sck = sample_on_fall;
    wait_clk(4);
  endtask

  task automatic expect_cmds(string tag, int n, logic [7:0] a, logic [7:0] b);
    check({tag, " strobe count"}, obs.size(), n);
    if (n > 0 && obs.size() > 0) check({tag, " first byte"}, obs[0], a);
    if (n > 1 && obs.size() > 1) check({tag, " second byte"}, obs[1], b);
    obs.delete();
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] got;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(2);
    check("R6 reset miso_oe", miso_oe, 0);
    check("R10 reset cmd_valid", cmd_valid, 0);
    check("R1 reset cmd_data", cmd_data, 0);

    // R2: rising-edge sampling, single byte, status 0xA5
    sample_on_fall = 0; spi_sck = 0; stat_word = 8'hA5;
    select(1);
    check("R6 oe while selected", miso_oe, 1);
    xfer(8'h3C, 8, got);
    check("R2 status returned", got, 8'hA5);
    select(0);
    check("R6 oe after deselect", miso_oe, 0);
    expect_cmds("R2", 1, 8'h3C, 0);

    // R8: burst of two, status changed mid-byte
    stat_word = 8'h81;
    select(1);
    stat_word = 8'h5E;
    xfer(8'hF0, 8, got);
    check("R7 first status captured at select", got, 8'h81);
    xfer(8'h0F, 8, got);
    check("R8 reloaded status", got, 8'h5E);
    select(0);
    expect_cmds("R8", 2, 8'hF0, 8'h0F);

    // R5: aborted byte then clean byte
    select(1);
    xfer(8'hFF, 5, got);
    select(0);
    expect_cmds("R5 aborted", 0, 0, 0);
    check("R10 no strobe while idle", cmd_valid, 0);
    select(1);
    xfer(8'h96, 8, got);
    select(0);
    expect_cmds("R5 realigned", 1, 8'h96, 0);

    // R3: falling-edge sampling
    sample_on_fall = 1; spi_sck = 1; stat_word = 8'hC3;
    wait_clk(HALF);
    select(1);
    xfer(8'h5A, 8, got);
    check("R3 status returned", got, 8'hC3);
    xfer(8'h01, 8, got);
    select(0);
    expect_cmds("R3", 2, 8'h5A, 8'h01);

    // R9: select held low, one spurious pulse misaligns later bytes
    sample_on_fall = 0; spi_sck = 0;
    wait_clk(HALF);
    select(1);
    xfer(8'h11, 8, got);
    glitch(1'b1);
    xfer(8'hAA, 8, got);
    xfer(8'h55, 8, got);
    expect_cmds("R9 misaligned", 3, 8'h11, {1'b1, 7'h55});
    select(0);
    select(1);
    xfer(8'h77, 8, got);
    select(0);
    expect_cmds("R9 recovered by deselect", 1, 8'h77, 0);

    wait_clk(10);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule